// File: doc/BRIEF.md
# Follow-State Macro Sequencer

This block completes multi-cycle instructions by stepping through short stored programs of follow states. A decoder elsewhere starts it with an index into a small computed ROM. Each entry in that ROM names one routine: a byte read, a byte write, or an end state. The sequencer spends one cycle in a dispatch state that consumes the entry at the macro pointer and advances that pointer. It then runs the chosen routine against the memory bus and comes back to dispatch for the next entry.

Reads and writes take their address and write data from holding registers. These are loaded when a start is accepted. A routine moves one byte, either the low half or the high half of a 16-bit word. The high byte lives at the next address. Read bytes collect into a 16-bit result register. A chain can stop in three ways: an entry flagged as a fetch return, an entry flagged as terminal (the routine runs, then control returns), or an end-state code. When control returns to fetch, the block raises a single-cycle done pulse.

Top module: `follow_seq`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, mem_rd_o and mem_wr_o are low and rd_data_o is zero.
- R2: A start_i seen while idle copies hold_addr_i and hold_data_i into the holding registers, clears rd_data_o, and loads start_idx_i into the macro pointer. busy_o is high from the next cycle on.
- R3: ROM entries are 8 bits: bit 7 flags a fetch return, bit 6 flags terminal, and bits 5:0 hold a code. The codes are 1 read low, 2 read high, 3 write low, 4 write high, 5 end. The dispatch state lasts one cycle, consumes the entry at the pointer, and adds one to the pointer.
- R4: A read routine lasts two cycles. mem_rd_o is high only in the first of them, and mem_rdata_i is captured into the selected byte of rd_data_o at the end of that cycle.
- R5: A write routine lasts four cycles and drives mem_addr_o and mem_wdata_o throughout. mem_wr_o is high only in the second cycle.
- R6: Low-byte routines use the held address and the low data byte. High-byte routines use the held address plus one, wrapping at 16 bits, and the high data byte.
- R7: An entry with the fetch-return flag set ends the chain from the dispatch cycle itself.
- R8: An entry with the terminal flag set runs its routine and then returns to fetch without another dispatch.
- R9: Code 5, and every code outside 1 to 4, enters a one-cycle end state that returns to fetch.
- R10: done_o is a single-cycle pulse in the first idle cycle after a chain. busy_o is low in that cycle.
- R11: start_i has no effect while busy: the running chain, its bus traffic and its result do not change.
- R12: mem_rd_o and mem_wr_o are never high in the same cycle.
- R13: ROM contents are as follows. Index 0: read low, read high+terminal. Index 3: write low, write high, fetch return. Index 6: read low, read high, write low, write high, end. Index 12: read low, fetch return. Every other index holds a fetch return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start a chain (taken only when idle) |
| start_idx_i | input | IDX_W | ROM index of the first entry |
| hold_addr_i | input | AW | Address loaded into the address holding register |
| hold_data_i | input | 2*DW | Word loaded into the write data holding register |
| busy_o | output | 1 | A chain is running |
| done_o | output | 1 | One-cycle pulse on return to fetch |
| mem_addr_o | output | AW | Memory address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | DW | Write data byte |
| mem_rdata_i | input | DW | Read data byte |
| rd_data_o | output | 2*DW | Bytes collected by read routines |

## Verification
Some rules are checked on every cycle by assertions. These cover strobe exclusion, the one-cycle read and write strobes, stable address and data across a write strobe, the pointer step in dispatch, and the done pulse landing on an idle cycle. Other behaviours only show up in the bench scenarios. These include the exact cycle count of each ROM program under each way of ending, the byte order and the 16-bit address wrap, and the values left in memory and in rd_data_o. They also include the proof that a start issued mid-chain leaves both the traffic and the result untouched.

// File: rtl/fsq_pkg.sv
`timescale 1ns/1ps
package fsq_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_MACRO, PH_RD1, PH_RD2, PH_WR1, PH_WR2, PH_WR3, PH_WR4, PH_END
  } phase_e;

  localparam int CODE_W = 6;

  typedef struct packed {
    logic              fetch_ret;
    logic              term;
    logic [CODE_W-1:0] code;
  } entry_t;

  localparam logic [CODE_W-1:0] C_RD_LO = 6'd1;
  localparam logic [CODE_W-1:0] C_RD_HI = 6'd2;
  localparam logic [CODE_W-1:0] C_WR_LO = 6'd3;
  localparam logic [CODE_W-1:0] C_WR_HI = 6'd4;
  localparam logic [CODE_W-1:0] C_END   = 6'd5;

  function automatic entry_t mk_entry(input logic f, input logic t, input logic [CODE_W-1:0] c);
    entry_t e;
    e.fetch_ret = f;
    e.term      = t;
    e.code      = c;
    return e;
  endfunction
endpackage

// File: rtl/fsq_rst_sync.sv
`timescale 1ns/1ps
module fsq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/fsq_macro_rom.sv
`timescale 1ns/1ps
module fsq_macro_rom
  import fsq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0] idx,
  output entry_t           entry
);
  always_comb begin
    entry = mk_entry(1'b1, 1'b0, '0);
    case (int'(idx))
      0:  entry = mk_entry(1'b0, 1'b0, C_RD_LO);
      1:  entry = mk_entry(1'b0, 1'b1, C_RD_HI);
      3:  entry = mk_entry(1'b0, 1'b0, C_WR_LO);
      4:  entry = mk_entry(1'b0, 1'b0, C_WR_HI);
      5:  entry = mk_entry(1'b1, 1'b0, '0);
      6:  entry = mk_entry(1'b0, 1'b0, C_RD_LO);
      7:  entry = mk_entry(1'b0, 1'b0, C_RD_HI);
      8:  entry = mk_entry(1'b0, 1'b0, C_WR_LO);
      9:  entry = mk_entry(1'b0, 1'b0, C_WR_HI);
      10: entry = mk_entry(1'b0, 1'b0, C_END);
      12: entry = mk_entry(1'b0, 1'b0, C_RD_LO);
      13: entry = mk_entry(1'b1, 1'b0, '0);
      default: entry = mk_entry(1'b1, 1'b0, '0);
    endcase
  end
endmodule

// File: rtl/fsq_ctrl.sv
`timescale 1ns/1ps
module fsq_ctrl
  import fsq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  input  entry_t           entry,
  output logic [IDX_W-1:0] ptr,
  output phase_e           phase,
  output logic             hi_sel,
  output logic             accept,
  output logic             done
);
  phase_e           phase_q, phase_n;
  logic [IDX_W-1:0] ptr_q, ptr_n;
  logic             term_q, term_n;
  logic             hi_q, hi_n;
  logic             done_q, done_n;
  logic             route_end;

  assign accept = start && (phase_q == PH_IDLE);
  assign route_end = term_q;

  always_comb begin
    phase_n = phase_q;
    ptr_n   = ptr_q;
    term_n  = term_q;
    hi_n    = hi_q;
    case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_n = PH_MACRO;
          ptr_n   = start_idx;
          term_n  = 1'b0;
          hi_n    = 1'b0;
        end
      end
      PH_MACRO: begin
        ptr_n = ptr_q + IDX_W'(1);
        if (entry.fetch_ret) begin
          phase_n = PH_IDLE;
        end else begin
          term_n = entry.term;
          case (entry.code)
            C_RD_LO: begin phase_n = PH_RD1; hi_n = 1'b0; end
            C_RD_HI: begin phase_n = PH_RD1; hi_n = 1'b1; end
            C_WR_LO: begin phase_n = PH_WR1; hi_n = 1'b0; end
            C_WR_HI: begin phase_n = PH_WR1; hi_n = 1'b1; end
            default: phase_n = PH_END;
          endcase
        end
      end
      PH_RD1:  phase_n = PH_RD2;
      PH_RD2:  phase_n = route_end ? PH_IDLE : PH_MACRO;
      PH_WR1:  phase_n = PH_WR2;
      PH_WR2:  phase_n = PH_WR3;
      PH_WR3:  phase_n = PH_WR4;
      PH_WR4:  phase_n = route_end ? PH_IDLE : PH_MACRO;
      default: phase_n = PH_IDLE;
    endcase
  end

  assign done_n = (phase_q != PH_IDLE) && (phase_n == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ptr_q   <= '0;
      term_q  <= 1'b0;
      hi_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      ptr_q   <= ptr_n;
      term_q  <= term_n;
      hi_q    <= hi_n;
      done_q  <= done_n;
    end
  end

  assign ptr    = ptr_q;
  assign phase  = phase_q;
  assign hi_sel = hi_q;
  assign done   = done_q;

  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MACRO) |=> (ptr_q == $past(ptr_q) + IDX_W'(1)));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (phase_q == PH_IDLE));
  a_r11_start_in_end: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_END && start) |=> (phase_q == PH_IDLE));
  a_r4_read_two: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RD1) |=> (phase_q == PH_RD2));
endmodule

// File: rtl/fsq_xfer.sv
`timescale 1ns/1ps
module fsq_xfer
  import fsq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int LANES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [AW-1:0]       hold_addr,
  input  logic [LANES*DW-1:0] hold_data,
  input  phase_e              phase,
  input  logic                hi_sel,
  input  logic [DW-1:0]       mem_rdata,
  output logic [AW-1:0]       mem_addr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [DW-1:0]       mem_wdata,
  output logic [LANES*DW-1:0] rd_data
);
  logic [AW-1:0]       addr_q;
  logic [LANES*DW-1:0] wdat_q;
  logic                in_write;
  logic                capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else if (load) begin
      addr_q <= hold_addr;
      wdat_q <= hold_data;
    end
  end

  assign capture = (phase == PH_RD1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic          lane_en;
    logic [DW-1:0] lane_q;
    assign lane_en = capture && (int'(hi_sel) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (load)    lane_q <= '0;
      else if (lane_en) lane_q <= mem_rdata;
    end
    assign rd_data[g*DW +: DW] = lane_q;
  end

  assign in_write  = (phase == PH_WR1) || (phase == PH_WR2) ||
                     (phase == PH_WR3) || (phase == PH_WR4);
  assign mem_addr  = addr_q + {{(AW-1){1'b0}}, hi_sel};
  assign mem_rd    = (phase == PH_RD1);
  assign mem_wr    = (phase == PH_WR2);
  assign mem_wdata = in_write ? (hi_sel ? wdat_q[DW +: DW] : wdat_q[0 +: DW]) : '0;

  a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  a_r5_wr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);
  a_r5_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ($stable(mem_addr) && $stable(mem_wdata)));
  a_r4_rd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
endmodule

// File: rtl/follow_seq.sv
`timescale 1ns/1ps
module follow_seq
  import fsq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  start_idx_i,
  input  logic [AW-1:0]     hold_addr_i,
  input  logic [2*DW-1:0]   hold_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic [2*DW-1:0]   rd_data_o
);
  logic             rst_n_s;
  logic [IDX_W-1:0] ptr;
  entry_t           entry;
  phase_e           phase;
  logic             hi_sel;
  logic             accept;

  fsq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  fsq_macro_rom #(.DEPTH(DEPTH)) u_rom (
    .idx(ptr), .entry(entry)
  );

  fsq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .start(start_i), .start_idx(start_idx_i),
    .entry(entry), .ptr(ptr), .phase(phase), .hi_sel(hi_sel),
    .accept(accept), .done(done_o)
  );

  fsq_xfer #(.AW(AW), .DW(DW)) u_xfer (
    .clk(clk), .rst_n(rst_n_s), .load(accept), .hold_addr(hold_addr_i),
    .hold_data(hold_data_i), .phase(phase), .hi_sel(hi_sel),
    .mem_rdata(mem_rdata_i), .mem_addr(mem_addr_o), .mem_rd(mem_rd_o),
    .mem_wr(mem_wr_o), .mem_wdata(mem_wdata_o), .rd_data(rd_data_o)
  );

  assign busy_o = (phase != PH_IDLE);

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start_i && !busy_o) |=> busy_o);
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> !busy_o);
endmodule

// File: tb/follow_seq_tb_top.sv
`timescale 1ns/1ps
module follow_seq_tb_top;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [4:0]  start_idx_i;
  logic [15:0] hold_addr_i;
  logic [15:0] hold_data_i;
  logic        busy_o, done_o, mem_rd_o, mem_wr_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;
  logic [15:0] rd_data_o;
  logic [7:0]  mem [256];

  int n_chk = 0;
  int n_bad = 0;

  follow_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_idx_i(start_idx_i),
    .hold_addr_i(hold_addr_i), .hold_data_i(hold_data_i), .busy_o(busy_o),
    .done_o(done_o), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .rd_data_o(rd_data_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign mem_rdata_i = mem[mem_addr_o[7:0]];
  always @(posedge clk) if (mem_wr_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R13 program table: {busy cycles, read lo, read hi, write lo, write hi}
  function automatic logic [11:0] prog(input logic [4:0] idx);
    case (idx)
      5'd0:    return {8'd6,  4'b1100};
      5'd1:    return {8'd3,  4'b0100};
      5'd3:    return {8'd11, 4'b0011};
      5'd4:    return {8'd6,  4'b0001};
      5'd6:    return {8'd18, 4'b1111};
      5'd7:    return {8'd15, 4'b0111};
      5'd8:    return {8'd12, 4'b0011};
      5'd9:    return {8'd7,  4'b0001};
      5'd10:   return {8'd2,  4'b0000};
      5'd12:   return {8'd4,  4'b1000};
      default: return {8'd1,  4'b0000};
    endcase
  endfunction

  task automatic run_op(input logic [4:0] idx, input logic [15:0] a,
                        input logic [15:0] d, input bit poke);
    logic [11:0] p;
    logic [7:0]  lo_i, hi_i, old_lo, old_hi, exp_lo, exp_hi;
    logic [15:0] exp_rd;
    int n, rds, wrs;
    p = prog(idx);
    lo_i = a[7:0];
    hi_i = 8'(a + 16'd1);
    old_lo = mem[lo_i];
    old_hi = mem[hi_i];
    exp_rd = {p[2] ? old_hi : 8'h00, p[3] ? old_lo : 8'h00};
    exp_lo = p[1] ? d[7:0]  : old_lo;
    exp_hi = p[0] ? d[15:8] : old_hi;
    @(negedge clk);
    start_i = 1'b1; start_idx_i = idx; hold_addr_i = a; hold_data_i = d;
    @(negedge clk);
    start_i = 1'b0; hold_addr_i = 16'($urandom); hold_data_i = 16'($urandom);
    n = 0; rds = 0; wrs = 0;
    while (!done_o && n < 100) begin
      n++;
      if (mem_rd_o) rds++;
      if (mem_wr_o) wrs++;
      if (poke && n == 2) begin
        start_i = 1'b1; start_idx_i = 5'd6; hold_addr_i = ~a;
      end else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    check(n < 100, "R10 watchdog", n, p[11:4]);
    check(n == int'(p[11:4]), "R7/R8/R9/R11 busy cycles", n, p[11:4]);
    check(!busy_o, "R10 busy low with done", busy_o, 0);
    check(rds == int'(p[3]) + int'(p[2]), "R4 read strobes", rds, p[3]+p[2]);
    check(wrs == int'(p[1]) + int'(p[0]), "R5 write strobes", wrs, p[1]+p[0]);
    check(rd_data_o == exp_rd, "R6 read data", rd_data_o, exp_rd);
    if (lo_i != hi_i) begin
      check(mem[lo_i] == exp_lo, "R6 low byte memory", mem[lo_i], exp_lo);
      check(mem[hi_i] == exp_hi, "R6 high byte memory", mem[hi_i], exp_hi);
    end
    @(negedge clk);
    check(!done_o, "R10 done single cycle", done_o, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [4:0] pick [14];
    pick = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd12, 5'd13, 5'd20, 5'd31};
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    rst_n = 1'b0; start_i = 1'b0; start_idx_i = '0; hold_addr_i = '0; hold_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!busy_o && !done_o, "R1 idle after reset", {busy_o, done_o}, 0);
    check(!mem_rd_o && !mem_wr_o, "R1 strobes low", {mem_rd_o, mem_wr_o}, 0);
    check(rd_data_o == 16'h0, "R1 result zero", rd_data_o, 0);
    // R3/R13 directed programs, R2 start from idle
    run_op(5'd0, 16'h0010, 16'hA55A, 1'b0);
    run_op(5'd6, 16'h0020, 16'h1234, 1'b0);
    run_op(5'd3, 16'h0030, 16'hBEEF, 1'b0);
    run_op(5'd10, 16'h0040, 16'h0000, 1'b0);
    run_op(5'd12, 16'h0050, 16'h0000, 1'b0);
    // R6 16-bit wrap: high byte at 0x0000
    run_op(5'd6, 16'hFFFF, 16'hC3D4, 1'b0);
    // R11 start during busy ignored
    run_op(5'd3, 16'h0060, 16'h7788, 1'b1);
    run_op(5'd0, 16'h0070, 16'h0000, 1'b1);
    // constrained random mix
    for (int k = 0; k < 60; k++) begin
      logic [4:0] ix;
      ix = pick[$urandom % 14];
      run_op(ix, 16'($urandom), 16'($urandom), ((prog(ix) >> 4) >= 12'd3) && ($urandom % 3 == 0));
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule